// File: doc/BRIEF.md
# Calendar Transaction Sequencer

This block drives a serial byte master that talks to a battery-backed clock chip. It turns one high-level command into the ordered list of single-register transactions that the command needs. The supported commands are: load a full date and time, fetch a full date and time, check that the chip is present, and program the battery charger. Time values on the command side are plain binary, with the month counted from zero and the year counted from 1900. The chip itself keeps packed two-digit BCD. The block converts in both directions.

Each transaction is offered on a request/acknowledge pair. The request carries a 6-bit register address, a direction and write data. The byte master completes it with a one-cycle acknowledge, and for reads it returns the byte in the same cycle. The chip register addresses are: seconds 0, minutes 1, hours 2, day of month 3, month 4, weekday 5, year 6, control 7, charger 8 and scratch RAM 0x20. Bit 7 of the seconds register halts the oscillator. Bit 7 of the control register is write protect.

Top module: `rtc_cal_seq`

## Requirements
- R1: After reset, `busy`, `done` and `txn_req` are low, and no transaction is requested until a command is accepted.
- R2: A load command (`cmd_op`=0) issues 13 transactions in this order: write 0x00 to register 7, read register 0, write register 0, write registers 0,1,2,5,3,4,6, read register 0, write register 0, write 0x80 to register 7.
- R3: The first write-back of register 0 is the byte just read with bit 7 set. The last write-back of register 0 is the byte just read with bit 7 cleared.
- R4: The seven field writes carry BCD (tens in bits 7:4, units in 3:0) of seconds, minutes, hours, weekday, day of month, month plus one, and year modulo 100, in that order.
- R5: A fetch command (`cmd_op`=1) issues seven reads of registers 0,1,2,5,3,4,6, in that order. The binary results are then presented on the `get_*` outputs, with the month reduced by one and seconds bit 7 ignored.
- R6: On fetch, a two-digit year below 70 is reported plus 100. Values 70 to 99 are reported unchanged.
- R7: A probe command (`cmd_op`=2) writes 0x42 to register 0x20 and reads it back. `present` is high only if the byte read back is 0x42.
- R8: A charger command (`cmd_op`=3) writes a single byte to register 8. Its upper nibble is 0xA and its lower nibble is `chg_sel`.
- R9: Each accepted command ends with exactly one single-cycle `done` pulse, one cycle after the last acknowledge. The results are valid from that cycle on.
- R10: `cmd_valid` while `busy` is high is ignored: it starts no transaction and produces no extra `done`.
- R11: While `txn_req` is high and not yet acknowledged, the address, direction and write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cmd_valid | input | 1 | command strobe |
| cmd_op | input | 2 | 0 load, 1 fetch, 2 probe, 3 charger |
| set_sec | input | 8 | binary seconds to load |
| set_min | input | 8 | binary minutes to load |
| set_hour | input | 8 | binary hours to load |
| set_wday | input | 8 | binary weekday to load |
| set_mday | input | 8 | binary day of month to load |
| set_mon | input | 8 | month to load, 0-based |
| set_year | input | 8 | years since 1900 to load |
| chg_sel | input | 4 | charger select nibble |
| busy | output | 1 | command in progress |
| done | output | 1 | completion pulse |
| present | output | 1 | probe result |
| get_sec | output | 8 | fetched seconds |
| get_min | output | 8 | fetched minutes |
| get_hour | output | 8 | fetched hours |
| get_wday | output | 8 | fetched weekday |
| get_mday | output | 8 | fetched day of month |
| get_mon | output | 8 | fetched month, 0-based |
| get_year | output | 8 | fetched years since 1900 |
| txn_req | output | 1 | transaction request |
| txn_write | output | 1 | 1 write, 0 read |
| txn_addr | output | 6 | register address |
| txn_wdata | output | 8 | write byte |
| txn_ack | input | 1 | transaction complete |
| txn_rdata | input | 8 | read byte, valid with ack |

## Verification
The assertions assume that load fields are in calendar range (0 to 99 after the month and year adjustments) and that the chip returns valid BCD digits. The digit and year-range checks rely on both. They also assume that the byte master never acknowledges without a pending request. The stimulus uses only in-range field values and stores only BCD bytes in the chip model. Its modelled byte master acknowledges only a held request, and only after a latency.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NFIELD  = 7;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 4;
  localparam int FLD_W   = $clog2(NFIELD);
  localparam logic [ADDR_W-1:0] A_SEC  = 6'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 6'd7;
  localparam logic [ADDR_W-1:0] A_CHG  = 6'd8;
  localparam logic [ADDR_W-1:0] A_RAM  = 6'h20;
  localparam logic [DATA_W-1:0] PROBE_PAT = 8'h42;
  localparam logic [DATA_W-1:0] WP_OFF = 8'h00;
  localparam logic [DATA_W-1:0] WP_ON  = 8'h80;
  localparam int YEAR_PIVOT = 70;

  typedef enum logic [1:0] {OP_SET = 2'd0, OP_GET = 2'd1, OP_PROBE = 2'd2, OP_CHARGE = 2'd3} op_e;
  typedef enum logic [2:0] {SRC_CONST, SRC_HALT, SRC_RUN, SRC_FIELD, SRC_CHG} src_e;

  typedef struct packed {
    logic              last;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    src_e              src;
    logic [DATA_W-1:0] konst;
    logic [FLD_W-1:0]  fld;
  } step_t;

  // field order: sec, min, hour, wday, mday, mon, year
  function automatic logic [ADDR_W-1:0] field_addr(input logic [FLD_W-1:0] f);
    case (f)
      3'd0: return 6'd0;
      3'd1: return 6'd1;
      3'd2: return 6'd2;
      3'd3: return 6'd5;
      3'd4: return 6'd3;
      3'd5: return 6'd4;
      default: return 6'd6;
    endcase
  endfunction

  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    logic [7:0] t;
    logic [7:0] u;
    t = v / 8'd10;
    u = v % 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [7:0] from_bcd(input logic [7:0] b);
    return 8'({4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]});
  endfunction
endpackage

// File: rtl/rtc_cal_steps.sv
module rtc_cal_steps
  import rtc_cal_pkg::*;
(
  input  op_e              op,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  localparam int SET_FLD0 = 3;
  localparam int SET_LAST = SET_FLD0 + NFIELD + 2;

  always_comb begin
    step = '{last: 1'b0, wr: 1'b0, addr: A_SEC, src: SRC_CONST, konst: 8'h00, fld: '0};
    case (op)
      OP_SET: begin
        if (idx == 0) begin
          step.wr = 1'b1; step.addr = A_CTRL; step.konst = WP_OFF;
        end else if (idx == 1 || idx == IDX_W'(SET_LAST - 2)) begin
          step.wr = 1'b0; step.addr = A_SEC;
        end else if (idx == 2) begin
          step.wr = 1'b1; step.addr = A_SEC; step.src = SRC_HALT;
        end else if (idx == IDX_W'(SET_LAST - 1)) begin
          step.wr = 1'b1; step.addr = A_SEC; step.src = SRC_RUN;
        end else if (idx == IDX_W'(SET_LAST)) begin
          step.wr = 1'b1; step.addr = A_CTRL; step.konst = WP_ON; step.last = 1'b1;
        end else begin
          step.wr   = 1'b1;
          step.src  = SRC_FIELD;
          step.fld  = FLD_W'(idx - IDX_W'(SET_FLD0));
          step.addr = field_addr(step.fld);
        end
      end
      OP_GET: begin
        step.fld  = FLD_W'(idx);
        step.addr = field_addr(step.fld);
        step.last = (idx == IDX_W'(NFIELD - 1));
      end
      OP_PROBE: begin
        step.addr  = A_RAM;
        step.wr    = (idx == 0);
        step.konst = PROBE_PAT;
        step.last  = (idx != 0);
      end
      default: begin
        step.wr = 1'b1; step.addr = A_CHG; step.src = SRC_CHG; step.last = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rtc_cal_pack.sv
module rtc_cal_pack
  import rtc_cal_pkg::*;
(
  input  logic [NFIELD-1:0][7:0] bin_in,
  output logic [NFIELD-1:0][7:0] bcd_out
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    logic [7:0] adj;
    always_comb begin
      if (g == 5)      adj = bin_in[g] + 8'd1;
      else if (g == 6) adj = bin_in[g] % 8'd100;
      else             adj = bin_in[g];
      bcd_out[g] = to_bcd(adj);
    end
    always_comb begin
      if (!$isunknown(adj) && adj <= 8'd99)
        assert_bcd_digit_R4: assert (bcd_out[g][3:0] <= 4'd9 && bcd_out[g][7:4] <= 4'd9);
    end
  end
endmodule

// File: rtl/rtc_cal_unpack.sv
module rtc_cal_unpack
  import rtc_cal_pkg::*;
(
  input  logic [NFIELD-1:0][7:0] raw_in,
  output logic [NFIELD-1:0][7:0] bin_out
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    logic [7:0] plain;
    always_comb begin
      if (g == 0) plain = from_bcd({1'b0, raw_in[g][6:0]});
      else        plain = from_bcd(raw_in[g]);
      if (g == 5)      bin_out[g] = plain - 8'd1;
      else if (g == 6) bin_out[g] = (plain < 8'(YEAR_PIVOT)) ? plain + 8'd100 : plain;
      else             bin_out[g] = plain;
    end
  end
  always_comb begin
    if (!$isunknown(raw_in[6]) && raw_in[6][7:4] <= 4'd9 && raw_in[6][3:0] <= 4'd9)
      assert_year_window_R6: assert (bin_out[6] >= 8'd70 && bin_out[6] <= 8'd169);
  end
endmodule

// File: rtl/rtc_cal_seq.sv
module rtc_cal_seq
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] set_sec,
  input  logic [7:0] set_min,
  input  logic [7:0] set_hour,
  input  logic [7:0] set_wday,
  input  logic [7:0] set_mday,
  input  logic [7:0] set_mon,
  input  logic [7:0] set_year,
  input  logic [3:0] chg_sel,
  output logic       busy,
  output logic       done,
  output logic       present,
  output logic [7:0] get_sec,
  output logic [7:0] get_min,
  output logic [7:0] get_hour,
  output logic [7:0] get_wday,
  output logic [7:0] get_mday,
  output logic [7:0] get_mon,
  output logic [7:0] get_year,
  output logic       txn_req,
  output logic       txn_write,
  output logic [5:0] txn_addr,
  output logic [7:0] txn_wdata,
  input  logic       txn_ack,
  input  logic [7:0] txn_rdata
);
  logic                    busy_q, done_q, present_q;
  op_e                     op_q;
  logic [IDX_W-1:0]        idx_q;
  logic [7:0]              last_rd_q;
  logic [3:0]              chg_q;
  logic [NFIELD-1:0][7:0]  bin_q, bcd_w, raw_q, get_w;
  step_t                   step;

  // named events
  logic cmd_accept, step_ack, step_last;
  assign cmd_accept = cmd_valid && !busy_q;
  assign step_ack   = busy_q && txn_ack;
  assign step_last  = step_ack && step.last;

  rtc_cal_steps u_steps (.op(op_q), .idx(idx_q), .step(step));
  rtc_cal_pack  u_pack  (.bin_in(bin_q), .bcd_out(bcd_w));
  rtc_cal_unpack u_unpack (.raw_in(raw_q), .bin_out(get_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; present_q <= 1'b0;
      op_q <= OP_SET; idx_q <= '0; last_rd_q <= '0; chg_q <= '0;
      bin_q <= '0; raw_q <= '0;
    end else begin
      done_q <= step_last;
      if (cmd_accept) begin
        busy_q <= 1'b1;
        op_q   <= op_e'(cmd_op);
        idx_q  <= '0;
        chg_q  <= chg_sel;
        bin_q  <= {set_year, set_mon, set_mday, set_wday, set_hour, set_min, set_sec};
      end else if (step_ack) begin
        idx_q <= idx_q + 1'b1;
        if (step.last) busy_q <= 1'b0;
        if (!step.wr) begin
          last_rd_q <= txn_rdata;
          if (op_q == OP_GET)   raw_q[step.fld] <= txn_rdata;
          if (op_q == OP_PROBE) present_q <= (txn_rdata == PROBE_PAT);
        end
      end
    end
  end

  always_comb begin
    case (step.src)
      SRC_HALT:  txn_wdata = last_rd_q | 8'h80;
      SRC_RUN:   txn_wdata = last_rd_q & 8'h7F;
      SRC_FIELD: txn_wdata = bcd_w[step.fld];
      SRC_CHG:   txn_wdata = {4'hA, chg_q};
      default:   txn_wdata = step.konst;
    endcase
  end

  assign txn_req   = busy_q;
  assign txn_write = step.wr;
  assign txn_addr  = step.addr;
  assign busy      = busy_q;
  assign done      = done_q;
  assign present   = present_q;
  assign get_sec   = get_w[0];
  assign get_min   = get_w[1];
  assign get_hour  = get_w[2];
  assign get_wday  = get_w[3];
  assign get_mday  = get_w[4];
  assign get_mon   = get_w[5];
  assign get_year  = get_w[6];

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_follows_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_last |=> done && !busy);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && !txn_ack) |=> txn_req && $stable(txn_addr) && $stable(txn_write) && $stable(txn_wdata));
  assert_ctrl_only_wp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_write && txn_addr == A_CTRL) |-> (txn_wdata == WP_OFF || txn_wdata == WP_ON));
  assert_busy_ignores_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !txn_ack) |=> busy && $stable(txn_addr));
  assert_halt_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_write && step.src == SRC_HALT) |-> txn_wdata[7] && txn_addr == A_SEC);
endmodule

// File: tb/rtc_cal_seq_test.sv
`timescale 1ns/1ps
module rtc_cal_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] s_sec = 0, s_min = 0, s_hour = 0, s_wday = 0, s_mday = 0, s_mon = 0, s_year = 0;
  logic [3:0] chg_sel = 0;
  logic busy, done, present, txn_req, txn_write;
  logic [7:0] g_sec, g_min, g_hour, g_wday, g_mday, g_mon, g_year, txn_wdata;
  logic [5:0] txn_addr;
  logic txn_ack = 1'b0;
  logic [7:0] txn_rdata = 8'h00;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] mem [0:63];
  bit absent = 0;
  int tr_n = 0;
  logic [5:0] tr_a [0:31];
  logic       tr_w [0:31];
  logic [7:0] tr_d [0:31];
  int done_cnt = 0;

  always #2.5 clk = ~clk;

  rtc_cal_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .set_sec(s_sec), .set_min(s_min), .set_hour(s_hour), .set_wday(s_wday),
    .set_mday(s_mday), .set_mon(s_mon), .set_year(s_year), .chg_sel(chg_sel),
    .busy(busy), .done(done), .present(present),
    .get_sec(g_sec), .get_min(g_min), .get_hour(g_hour), .get_wday(g_wday),
    .get_mday(g_mday), .get_mon(g_mon), .get_year(g_year),
    .txn_req(txn_req), .txn_write(txn_write), .txn_addr(txn_addr), .txn_wdata(txn_wdata),
    .txn_ack(txn_ack), .txn_rdata(txn_rdata));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // byte master and chip model
  initial begin
    forever begin
      @(negedge clk);
      if (txn_req && rst_n) begin
        @(negedge clk);
        if (tr_n < 32) begin
          tr_a[tr_n] = txn_addr; tr_w[tr_n] = txn_write; tr_d[tr_n] = txn_wdata;
        end
        tr_n++;
        if (txn_write) mem[txn_addr] = txn_wdata;
        txn_rdata = absent ? 8'hFF : mem[txn_addr];
        txn_ack = 1'b1;
        @(negedge clk);
        txn_ack = 1'b0;
      end
    end
  end

  always @(posedge clk) if (done) done_cnt++;

  task automatic run(input logic [1:0] op);
    int t;
    tr_n = 0; done_cnt = 0;
    @(negedge clk);
    cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
  endtask

  task automatic chk_txn(input int i, input bit w, input int a, input int d, input string req);
    chk(tr_w[i] == w && tr_a[i] == 6'(a) && (!w || tr_d[i] == 8'(d)), req,
        {tr_w[i], 2'b0, tr_a[i], tr_d[i]}, {w, 2'b0, 6'(a), 8'(d)});
  endtask

  task automatic t_reset;
    chk(!busy && !done && !txn_req, "R1 reset idle", {busy, done, txn_req}, 0);
    repeat (4) @(negedge clk);
    chk(tr_n == 0 && !txn_req, "R1 no traffic", tr_n, 0);
  endtask

  task automatic t_set;
    int exp_a [7] = '{0, 1, 2, 5, 3, 4, 6};
    int exp_v [7];
    mem[0] = 8'h12;
    s_sec = 45; s_min = 7; s_hour = 23; s_wday = 3; s_mday = 31; s_mon = 11; s_year = 124;
    exp_v = '{45, 7, 23, 3, 31, 12, 24};
    run(2'd0);
    chk(tr_n == 13, "R2 transaction count", tr_n, 13);
    chk_txn(0, 1, 7, 8'h00, "R2 unprotect");
    chk_txn(1, 0, 0, 0, "R2 read sec");
    chk_txn(2, 1, 0, 8'h92, "R3 halt write-back");
    for (int i = 0; i < 7; i++) chk_txn(3 + i, 1, exp_a[i], bcd(exp_v[i]), "R4 field write");
    chk_txn(10, 0, 0, 0, "R2 reread sec");
    chk_txn(11, 1, 0, 8'h45, "R3 restart write-back");
    chk_txn(12, 1, 7, 8'h80, "R2 protect");
  endtask

  task automatic t_get;
    run(2'd1);
    chk(tr_n == 7, "R5 read count", tr_n, 7);
    for (int i = 0; i < 7; i++) begin
      int a;
      a = (i == 3) ? 5 : (i == 4) ? 3 : (i == 5) ? 4 : i;
      chk_txn(i, 0, a, 0, "R5 read order");
    end
    chk(g_sec == 45 && g_min == 7 && g_hour == 23, "R5 time", {g_sec, g_min, g_hour}, {8'd45, 8'd7, 8'd23});
    chk(g_wday == 3 && g_mday == 31 && g_mon == 11, "R5 date", {g_wday, g_mday, g_mon}, {8'd3, 8'd31, 8'd11});
    chk(g_year == 124, "R6 year 24", g_year, 124);
  endtask

  task automatic t_year_edges;
    mem[6] = 8'h69; mem[0] = 8'hB0; mem[4] = 8'h01;
    run(2'd1);
    chk(g_year == 169, "R6 year 69", g_year, 169);
    chk(g_sec == 30, "R5 halt bit ignored", g_sec, 30);
    chk(g_mon == 0, "R5 month january", g_mon, 0);
    mem[6] = 8'h70;
    run(2'd1);
    chk(g_year == 70, "R6 year 70", g_year, 70);
    mem[6] = 8'h00;
    run(2'd1);
    chk(g_year == 100, "R6 year 00", g_year, 100);
  endtask

  task automatic t_year_mod;
    s_sec = 0; s_min = 59; s_hour = 0; s_wday = 7; s_mday = 1; s_mon = 0; s_year = 99;
    run(2'd0);
    chk_txn(9, 1, 6, 8'h99, "R4 year 99");
    chk_txn(8, 1, 4, 8'h01, "R4 month plus one");
    chk_txn(4, 1, 1, 8'h59, "R4 minutes");
  endtask

  task automatic t_probe;
    mem[32] = 8'h00; absent = 0;
    run(2'd2);
    chk(tr_n == 2, "R7 probe count", tr_n, 2);
    chk_txn(0, 1, 32, 8'h42, "R7 pattern write");
    chk_txn(1, 0, 32, 0, "R7 readback");
    chk(present == 1'b1, "R7 present", present, 1);
    absent = 1;
    run(2'd2);
    chk(present == 1'b0, "R7 absent", present, 0);
    absent = 0;
  endtask

  task automatic t_charge;
    chg_sel = 4'h5;
    run(2'd3);
    chk(tr_n == 1, "R8 count", tr_n, 1);
    chk_txn(0, 1, 8, 8'hA5, "R8 charger byte");
  endtask

  task automatic t_busy_ignore;
    int t;
    bit saw8;
    tr_n = 0; done_cnt = 0; mem[8] = 8'h00;
    @(negedge clk);
    cmd_op = 2'd1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 2'd3; chg_sel = 4'h3;
    repeat (4) @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    saw8 = 0;
    for (int i = 0; i < tr_n && i < 32; i++) if (tr_a[i] == 6'd8) saw8 = 1;
    chk(tr_n == 7 && !saw8, "R10 busy command ignored", tr_n, 7);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(mem[8] == 8'h00, "R10 charger untouched", mem[8], 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    #1;
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_set;
    t_get;
    t_year_edges;
    t_year_mod;
    t_probe;
    t_charge;
    t_busy_ignore;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule